// File: doc/BRIEF.md
# Floating-Point Round-to-Integral Unit (Ties Away From Zero)

This unit takes one scalar IEEE-754 value (half, single or double precision) from the low bits of a 128-bit source word. It returns the nearest integral value in the same precision. A value lying exactly halfway between two integers always goes to the one of larger magnitude. The unit has no rounding-mode input at all, so no configured mode can change this behaviour. Zeros, infinities, NaNs and subnormals are all handled.

The rounded value occupies the lowest element of a 128-bit result word. The bits above that element are either copied from a supplied old destination word or forced to zero, as a merge-enable bit chooses. Each accepted operation produces its result one clock after the input strobe. A sticky invalid-operation flag records any signaling NaN seen since reset. The unit drives no condition flags.

Top module: `fp_rint_away`

## Requirements
- R1: A value whose fractional part is exactly one half rounds to the integer of larger magnitude (2.5 gives 3, -2.5 gives -3, 1.5 gives 2). Any other value rounds to the nearest integer. A carry out of the significand raises the exponent by one.
- R2: The precision code is interpreted as follows: 00 selects single precision in result bits [31:0], 01 selects double precision in bits [63:0], and 11 selects half precision in bits [15:0]. Source bits above the selected width do not affect the result.
- R3: A zero of either sign is returned as a zero of the same sign.
- R4: An infinity of either sign is returned unchanged.
- R5: A quiet NaN (top fraction bit set) is returned unchanged, and the invalid flag is left as it was. A signaling NaN (top fraction bit clear, fraction non-zero) is returned with its top fraction bit set, and it sets the invalid flag.
- R6: A finite value whose unbiased exponent is at least the fraction width (10, 23 or 52) is returned unchanged.
- R7: A magnitude below 0.5, including every subnormal, returns a zero with the input's sign. A magnitude from 0.5 up to, but not including, 1.0 returns one with the input's sign.
- R8: With merge enabled, result bits above the selected element equal the same bits of the old destination word. With merge disabled, those bits are zero.
- R9: The invalid flag stays set from the first signaling NaN until reset.
- R10: Precision code 10 is reserved. It gives an all-zero result and raises the illegal-format output, which is high only alongside such a result.
- R11: Every input strobe yields exactly one output strobe on the following clock edge, and no output strobe occurs without an input strobe. During reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| fmt | input | 2 | Precision code (00 single, 01 double, 11 half, 10 reserved) |
| merge_en | input | 1 | 1: keep upper bits of old_dst, 0: clear them |
| src | input | 128 | Source register word; operand in the low bits |
| old_dst | input | 128 | Previous destination word used for merging |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 128 | Rounded result word |
| illegal_fmt | output | 1 | Reserved precision code seen; valid with out_valid |
| flag_invalid | output | 1 | Sticky invalid-operation flag |

## Verification
The assertions assume that in_valid is held low while reset is asserted, and that in_valid, fmt and merge_en are never unknown on a clock edge. They also assume the reset is asynchronous, so that no output strobe is left over from before reset. The stimulus drives every input at the falling edge and keeps in_valid low during reset and between bursts. It uses every precision code, including the reserved one, with both settings of the merge bit. Source upper bits and old-destination words are filled with distinct non-zero patterns, so that a wrong merge or a leak of unused source bits shows up in the result word.

// File: rtl/fpri_pkg.sv
package fpri_pkg;

   typedef enum logic [1:0] {
      FMT_SINGLE = 2'b00,
      FMT_DOUBLE = 2'b01,
      FMT_RSVD   = 2'b10,
      FMT_HALF   = 2'b11
   } fpri_fmt_e;

   localparam int NUM_FMT = 3;
   localparam int MAX_W   = 64;

   function automatic int exp_w(input int idx);
      case (idx)
         0:       return 8;
         1:       return 11;
         default: return 5;
      endcase
   endfunction

   function automatic int frac_w(input int idx);
      case (idx)
         0:       return 23;
         1:       return 52;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/fpri_round_lane.sv
module fpri_round_lane #(
   parameter int EW = 8,
   parameter int FW = 23,
   localparam int W = 1 + EW + FW
) (
   input  logic [W-1:0] op,
   output logic [W-1:0] res,
   output logic         snan
);
   localparam int BIAS = (1 << (EW - 1)) - 1;
   localparam int MW   = FW + 2;

   if (EW < 3 || FW < 2) begin : g_bad_shape
      $error("fpri_round_lane: exponent or fraction too narrow");
   end
   if (BIAS + FW >= (1 << EW) - 1) begin : g_bad_range
      $error("fpri_round_lane: integral threshold exceeds exponent range");
   end

   logic          sgn;
   logic [EW-1:0] ex;
   logic [FW-1:0] fr;
   logic [EW-1:0] drop;
   logic [MW-1:0] mant, half_ulp, keep_mask, sum;

   assign sgn = op[W-1];
   assign ex  = op[W-2:FW];
   assign fr  = op[FW-1:0];

   always_comb begin
      res       = op;
      snan      = 1'b0;
      drop      = '0;
      mant      = '0;
      half_ulp  = '0;
      keep_mask = '0;
      sum       = '0;
      if (ex == {EW{1'b1}}) begin
         if (fr != '0 && !fr[FW-1]) begin
            snan = 1'b1;
            res  = op | (W'(1) << (FW - 1));
         end
      end else if (ex < EW'(BIAS - 1)) begin
         res = {sgn, {(W-1){1'b0}}};
      end else if (ex == EW'(BIAS - 1)) begin
         res = {sgn, EW'(BIAS), {FW{1'b0}}};
      end else if (ex >= EW'(BIAS + FW)) begin
         res = op;
      end else begin
         drop      = EW'(BIAS + FW) - ex;
         mant      = {2'b01, fr};
         half_ulp  = MW'(1) << (drop - EW'(1));
         keep_mask = ~((MW'(1) << drop) - MW'(1));
         sum       = (mant + half_ulp) & keep_mask;
         if (sum[FW+1]) begin
            res = {sgn, ex + EW'(1), {FW{1'b0}}};
         end else begin
            res = {sgn, ex, sum[FW-1:0]};
         end
      end
   end

endmodule

// File: rtl/fpri_lane_place.sv
module fpri_lane_place #(
   parameter int REG_W = 128,
   parameter int W     = 32
) (
   input  logic [W-1:0]     lane,
   input  logic [REG_W-1:0] old_word,
   input  logic             merge_en,
   output logic [REG_W-1:0] full
);
   if (W > REG_W) begin : g_bad
      $error("fpri_lane_place: element wider than register");
   end else if (W == REG_W) begin : g_exact
      assign full = lane;
   end else begin : g_upper
      logic [REG_W-W-1:0] upper;
      assign upper = merge_en ? old_word[REG_W-1:W] : '0;
      assign full  = {upper, lane};
   end

endmodule

// File: rtl/fp_rint_away.sv
module fp_rint_away #(
   parameter int REG_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       fmt,
   input  logic             merge_en,
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] old_dst,
   output logic             out_valid,
   output logic [REG_W-1:0] result,
   output logic             illegal_fmt,
   output logic             flag_invalid
);
   import fpri_pkg::*;

   if (REG_W < MAX_W) begin : g_bad_width
      $error("fp_rint_away: REG_W must hold a double element");
   end

   logic [REG_W-1:0]   placed [NUM_FMT];
   logic [NUM_FMT-1:0] snan_v;

   for (genvar gi = 0; gi < NUM_FMT; gi++) begin : g_fmt
      localparam int EW = exp_w(gi);
      localparam int FW = frac_w(gi);
      localparam int W  = 1 + EW + FW;
      logic [W-1:0] lane_res;

      fpri_round_lane #(.EW(EW), .FW(FW)) u_lane (
         .op   (src[W-1:0]),
         .res  (lane_res),
         .snan (snan_v[gi])
      );

      fpri_lane_place #(.REG_W(REG_W), .W(W)) u_place (
         .lane     (lane_res),
         .old_word (old_dst),
         .merge_en (merge_en),
         .full     (placed[gi])
      );
   end

   logic [REG_W-1:0] sel_res;
   logic             sel_snan;
   logic             sel_ill;

   always_comb begin
      sel_res  = '0;
      sel_snan = 1'b0;
      sel_ill  = 1'b0;
      case (fpri_fmt_e'(fmt))
         FMT_SINGLE: begin sel_res = placed[0]; sel_snan = snan_v[0]; end
         FMT_DOUBLE: begin sel_res = placed[1]; sel_snan = snan_v[1]; end
         FMT_HALF:   begin sel_res = placed[2]; sel_snan = snan_v[2]; end
         default:    sel_ill = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         result       <= '0;
         illegal_fmt  <= 1'b0;
         flag_invalid <= 1'b0;
      end else begin
         out_valid   <= in_valid;
         illegal_fmt <= in_valid & sel_ill;
         if (in_valid) begin
            result <= sel_res;
         end
         if (in_valid && sel_snan) begin
            flag_invalid <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/fp_rint_away_chk.sv
module fp_rint_away_chk #(
   parameter int REG_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [1:0]       fmt,
   input logic             merge_en,
   input logic [REG_W-1:0] src,
   input logic [REG_W-1:0] old_dst,
   input logic             out_valid,
   input logic [REG_W-1:0] result,
   input logic             illegal_fmt,
   input logic             flag_invalid
);

   p_strobe_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_fmt |-> (out_valid && result == '0));

   p_illegal_only_rsvd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt != 2'b10) |=> !illegal_fmt);

   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_invalid |=> flag_invalid);

   p_merge_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && merge_en && fmt == 2'b01) |=>
         result[REG_W-1:64] == $past(old_dst[REG_W-1:64]));

   p_clear_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !merge_en && fmt == 2'b00) |=> result[REG_W-1:32] == '0);

   p_single_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt == 2'b00 && src[30:0] == 31'h7F80_0000) |=>
         result[31:0] == $past(src[31:0]));

   p_single_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && fmt == 2'b00 && src[30:0] == '0) |=>
         result[31:0] == $past(src[31:0]));

endmodule

bind fp_rint_away fp_rint_away_chk #(.REG_W(REG_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .fmt          (fmt),
   .merge_en     (merge_en),
   .src          (src),
   .old_dst      (old_dst),
   .out_valid    (out_valid),
   .result       (result),
   .illegal_fmt  (illegal_fmt),
   .flag_invalid (flag_invalid)
);

// File: tb/fp_rint_away_tb.sv
`timescale 1ns/1ps
module fp_rint_away_tb;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   fmt = 2'b00;
   logic         merge_en = 1'b0;
   logic [127:0] src = '0;
   logic [127:0] old_dst = '0;
   logic         out_valid;
   logic [127:0] result;
   logic         illegal_fmt;
   logic         flag_invalid;

   fp_rint_away #(.REG_W(128)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .fmt          (fmt),
      .merge_en     (merge_en),
      .src          (src),
      .old_dst      (old_dst),
      .out_valid    (out_valid),
      .result       (result),
      .illegal_fmt  (illegal_fmt),
      .flag_invalid (flag_invalid)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      logic [127:0] res;
      logic         ill;
      logic         flg;
      int           cyc;
      string        tag;
   } exp_t;

   exp_t   sb_q[$];
   int     total = 0;
   int     bad = 0;
   int     cyc = 0;
   logic   sticky_model = 1'b0;
   bit     finished = 1'b0;

   localparam logic [127:0] OLD_PAT = 128'hA5A5_1234_5678_9ABC_C3C3_0F0F_F0F0_5A5A;
   localparam logic [127:0] JUNK    = 128'hDEAD_BEEF_CAFE_F00D_0BAD_1DEA_7777_1111;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input logic [127:0] act,
                        input logic [127:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
      end
   endtask

   task automatic send(input logic [1:0] f, input logic m, input logic [63:0] op,
                       input logic [63:0] exp_low, input bit is_snan, input string tag);
      exp_t e;
      int   w;
      logic [127:0] full;
      @(negedge clk);
      in_valid = 1'b1;
      fmt      = f;
      merge_en = m;
      old_dst  = OLD_PAT;
      w = (f == 2'b00) ? 32 : (f == 2'b01) ? 64 : 16;
      src = JUNK;
      for (int i = 0; i < w; i++) src[i] = op[i];
      full = m ? OLD_PAT : '0;
      for (int i = 0; i < w; i++) full[i] = exp_low[i];
      if (f == 2'b10) full = '0;
      if (is_snan) sticky_model = 1'b1;
      e.res = full;
      e.ill = (f == 2'b10);
      e.flg = sticky_model;
      e.cyc = cyc;
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R11 unexpected output strobe", {127'd0, out_valid}, '0);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(result == e.res, e.tag, result, e.res);
            check(illegal_fmt == e.ill, {e.tag, " R10 illegal_fmt"},
                  {127'd0, illegal_fmt}, {127'd0, e.ill});
            check(flag_invalid == e.flg, {e.tag, " R9 R5 invalid flag"},
                  {127'd0, flag_invalid}, {127'd0, e.flg});
            check(cyc == e.cyc + 1, {e.tag, " R11 latency"}, 128'(cyc), 128'(e.cyc + 1));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check({out_valid, illegal_fmt, flag_invalid} == 3'b000 && result == '0,
            "R11 reset state", result, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 ties away and nearest, single
      send(2'b00, 1'b0, 64'h4020_0000, 64'h4040_0000, 0, "R1 single 2.5");
      send(2'b00, 1'b0, 64'hC020_0000, 64'hC040_0000, 0, "R1 single -2.5");
      send(2'b00, 1'b0, 64'h3FC0_0000, 64'h4000_0000, 0, "R1 single 1.5 carry");
      send(2'b00, 1'b0, 64'h4019_999A, 64'h4000_0000, 0, "R1 single 2.4");
      send(2'b00, 1'b0, 64'h4AFF_FFFF, 64'h4B00_0000, 0, "R1 single 8388607.5");
      // R7 small magnitudes
      send(2'b00, 1'b0, 64'h3F00_0000, 64'h3F80_0000, 0, "R7 single 0.5");
      send(2'b00, 1'b0, 64'hBF40_0000, 64'hBF80_0000, 0, "R7 single -0.75");
      send(2'b00, 1'b0, 64'h3E80_0000, 64'h0000_0000, 0, "R7 single 0.25");
      send(2'b00, 1'b0, 64'h8000_0001, 64'h8000_0000, 0, "R7 single -subnormal");
      // R3 zeros, R4 infinities
      send(2'b00, 1'b0, 64'h8000_0000, 64'h8000_0000, 0, "R3 single -0");
      send(2'b11, 1'b0, 64'h0000, 64'h0000, 0, "R3 half +0");
      send(2'b00, 1'b0, 64'h7F80_0000, 64'h7F80_0000, 0, "R4 single +inf");
      send(2'b00, 1'b1, 64'hFF80_0000, 64'hFF80_0000, 0, "R4 single -inf merged");
      send(2'b11, 1'b0, 64'h7C00, 64'h7C00, 0, "R4 half +inf");
      // R6 already integral
      send(2'b00, 1'b0, 64'h4B00_0000, 64'h4B00_0000, 0, "R6 single 2^23");
      send(2'b00, 1'b0, 64'h5015_02F9, 64'h5015_02F9, 0, "R6 single 1e10");
      send(2'b11, 1'b0, 64'h6400, 64'h6400, 0, "R6 half 1024");
      // R5 quiet NaN before any signaling NaN: flag stays clear
      send(2'b00, 1'b0, 64'h7FC0_0001, 64'h7FC0_0001, 0, "R5 single qNaN");
      // R2 double and half, R8 merge
      send(2'b01, 1'b0, 64'h4004_0000_0000_0000, 64'h4008_0000_0000_0000, 0, "R2 double 2.5");
      send(2'b01, 1'b1, 64'hBFF8_0000_0000_0000, 64'hC000_0000_0000_0000, 0, "R8 double -1.5 merged");
      send(2'b01, 1'b0, 64'h3FD3_3333_3333_3333, 64'h0, 0, "R7 double 0.3");
      send(2'b11, 1'b1, 64'h4100, 64'h4200, 0, "R8 half 2.5 merged");
      send(2'b11, 1'b0, 64'hB800, 64'hBC00, 0, "R7 half -0.5");
      send(2'b11, 1'b0, 64'h63FF, 64'h6400, 0, "R1 half 1023.5");
      send(2'b00, 1'b1, 64'h4020_0000, 64'h4040_0000, 0, "R8 single merged");
      // R10 reserved code
      send(2'b10, 1'b1, 64'h4020_0000, 64'h0, 0, "R10 reserved code");
      // R5 signaling NaNs, R9 sticky
      send(2'b00, 1'b0, 64'h7F80_0001, 64'h7FC0_0001, 1, "R5 single sNaN");
      send(2'b00, 1'b0, 64'h4020_0000, 64'h4040_0000, 0, "R9 flag held");
      send(2'b01, 1'b0, 64'h7FF0_0000_0000_0001, 64'h7FF8_0000_0000_0001, 1, "R5 double sNaN");
      send(2'b11, 1'b0, 64'h7D00, 64'h7F00, 1, "R5 half sNaN");

      @(negedge clk);
      in_valid = 1'b0;
      repeat (4) @(negedge clk);
      check(sb_q.size() == 0, "R11 all results delivered", 128'(sb_q.size()), '0);
      check(flag_invalid == 1'b1, "R9 flag after idle", {127'd0, flag_invalid}, 128'd1);
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule